// File: doc/BRIEF.md
# Flash Cycle Sequencer

This block lets software run one serial-flash operation at a time through a few registers. Software loads the target flash address, fills a 64-byte data buffer if the operation sends data, and then writes the control/status word. That single write carries the start bit, an operation code and a byte count encoded as length minus one. It may also carry ones that clear old completion flags. The sequencer then issues one command on an abstract flash command port. For write operations it streams the buffer bytes out. For read operations it collects the returned bytes into the buffer. It waits for the flash side to report completion and sets either a done flag or an error flag, which software polls.

The supported operations are read, write, read-status, 4 KiB erase and 64 KiB erase. Erase operations carry no data bytes. A data operation that asks for more bytes than the buffer holds is rejected with the error flag and never reaches the flash port. Serial clocking and chip-select timing belong to whatever sits behind the command port.

Top module: `flash_seq_ctrl`

## Requirements
- R1: After reset, the control/status word (offset 0x00), the address register (offset 0x04) and every buffer word (offsets 0x40 to 0x7F) read 0. cmd_valid_o and wr_valid_o are 0.
- R2: The control/status word has these fields: bit 0 done, bit 1 error, bit 2 busy (read-only), bits 6:4 operation, bits 15:8 count minus one, and bit 16 start (always reads 0). The operation codes are 1 read, 2 write, 3 read-status, 4 erase 4 KiB and 5 erase 64 KiB. A write that sets start while idle, with a legal request, sets busy on the next cycle. It then issues one command carrying the operation, the address register value, and a length of count plus one for data operations.
- R3: Busy stays 1 until the flash side reports completion. A completion without error clears busy and sets done with error 0. Busy is never 1 together with done or error.
- R4: A write operation sends buffer bytes 0 to length-1 in order on the write stream, one byte per wr_valid_o/wr_ready_i handshake, and then waits for completion.
- R5: Read and read-status operations store the returned bytes into the buffer starting at byte 0, in arrival order, before done is set. Buffer bytes at and above the length keep their earlier contents.
- R6: Erase operations issue a command with length 0 and make no data transfer.
- R7: A completion with error clears busy, sets error and leaves done 0. The operation and count fields stay readable in the same status word.
- R8: A start request is refused, with error set and no command issued, in two cases: a data operation whose count field exceeds 63, or an operation code of 0, 6 or 7.
- R9: Writing 1 to done or error clears that flag, and writing 0 leaves it unchanged. Any accepted start also clears both flags.
- R10: While busy, software writes to the control/status word, the address register and the buffer are ignored. A second start request therefore has no effect.
- R11: Software buffer writes are byte-granular. reg_be_i bit n selects byte lane n (bits 8n+7:8n) of the addressed buffer word. Writes to the control/status word and the address register always take all 32 bits.
- R12: A command held on cmd_valid_o keeps its operation, address and length unchanged until cmd_ready_i accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 7 | Register byte address (word aligned) |
| reg_be_i | input | 4 | Byte lane enables for buffer writes |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational on reg_addr_i) |
| cmd_valid_o | output | 1 | Flash command valid |
| cmd_ready_i | input | 1 | Flash command accepted |
| cmd_op_o | output | 3 | Command operation code |
| cmd_addr_o | output | 32 | Command flash address |
| cmd_len_o | output | 7 | Command byte length (0 for erase) |
| wr_valid_o | output | 1 | Outgoing data byte valid |
| wr_ready_i | input | 1 | Outgoing data byte taken |
| wr_data_o | output | 8 | Outgoing data byte |
| rd_valid_i | input | 1 | Incoming data byte valid |
| rd_data_i | input | 8 | Incoming data byte |
| rsp_valid_i | input | 1 | Operation completion strobe |
| rsp_err_i | input | 1 | Completion reports failure |

## Verification
Several properties are checked on every cycle. Busy never coexists with done or error. A stalled command keeps its fields stable. Erase commands carry length 0. Only write operations drive the write stream. The engine's byte counter stays within the length. The buffer never has two writers at once, and control and address state are frozen against writes while busy. Other behaviour is visible only through the bench's scenarios. These scenarios cover byte ordering on both data streams and buffer fill from byte 0 with untouched upper bytes. They also cover refusal of oversize counts and unknown codes without a command, and write-one-to-clear semantics. Finally, they cover a second start and buffer writes issued while a stalled operation is in flight.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 8;

  localparam int CTL_DONE    = 0;
  localparam int CTL_ERR     = 1;
  localparam int CTL_BUSY    = 2;
  localparam int CTL_OP_LSB  = 4;
  localparam int CTL_CNT_LSB = 8;
  localparam int CTL_GO      = 16;

  localparam logic [2:0] OP_READ  = 3'd1;
  localparam logic [2:0] OP_WRITE = 3'd2;
  localparam logic [2:0] OP_RDSR  = 3'd3;
  localparam logic [2:0] OP_ER4K  = 3'd4;
  localparam logic [2:0] OP_ER64K = 3'd5;

  function automatic logic op_known(input logic [2:0] op);
    return op inside {OP_READ, OP_WRITE, OP_RDSR, OP_ER4K, OP_ER64K};
  endfunction

  function automatic logic op_has_data(input logic [2:0] op);
    return op inside {OP_READ, OP_WRITE, OP_RDSR};
  endfunction

  function automatic logic op_is_erase(input logic [2:0] op);
    return op inside {OP_ER4K, OP_ER64K};
  endfunction
endpackage

// File: rtl/fseq_regs.sv
module fseq_regs
  import fseq_pkg::*;
#(
  parameter int BUF_BYTES = 64,
  parameter int ADDR_W    = 32,
  localparam int LEN_W    = $clog2(BUF_BYTES) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_we_i,
  input  logic              adr_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              fin_i,
  input  logic              fin_err_i,
  output logic              start_o,
  output logic [2:0]        start_op_o,
  output logic [LEN_W-1:0]  start_len_o,
  output logic [ADDR_W-1:0] faddr_o,
  output logic              busy_o,
  output logic [DATA_W-1:0] ctl_word_o
);
  logic              done_q, err_q, busy_q;
  logic [2:0]        op_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] faddr_q;

  logic [2:0]       op_w;
  logic [CNT_W-1:0] cnt_w;
  logic             ctl_take, go_req, legal;

  assign op_w     = wdata_i[CTL_OP_LSB +: 3];
  assign cnt_w    = wdata_i[CTL_CNT_LSB +: CNT_W];
  assign ctl_take = ctl_we_i && !busy_q;
  assign go_req   = ctl_take && wdata_i[CTL_GO];
  assign legal    = op_known(op_w) &&
                    (!op_has_data(op_w) || (cnt_w <= CNT_W'(BUF_BYTES - 1)));

  assign start_o     = go_req && legal;
  assign start_op_o  = op_w;
  assign start_len_o = op_has_data(op_w) ? (LEN_W'(cnt_w) + LEN_W'(1)) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      busy_q <= 1'b0;
      op_q   <= '0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (fin_i) begin
        busy_q <= 1'b0;
        done_q <= !fin_err_i;
        err_q  <= fin_err_i;
      end
    end else if (ctl_take) begin
      op_q  <= op_w;
      cnt_q <= cnt_w;
      if (go_req) begin
        done_q <= 1'b0;
        err_q  <= !legal;
        busy_q <= legal;
      end else begin
        done_q <= done_q && !wdata_i[CTL_DONE];
        err_q  <= err_q && !wdata_i[CTL_ERR];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  faddr_q <= '0;
    else if (adr_we_i && !busy_q) faddr_q <= wdata_i[ADDR_W-1:0];
  end

  assign faddr_o = faddr_q;
  assign busy_o  = busy_q;

  always_comb begin
    ctl_word_o = '0;
    ctl_word_o[CTL_DONE] = done_q;
    ctl_word_o[CTL_ERR]  = err_q;
    ctl_word_o[CTL_BUSY] = busy_q;
    ctl_word_o[CTL_OP_LSB +: 3] = op_q;
    ctl_word_o[CTL_CNT_LSB +: CNT_W] = cnt_q;
  end

  p_busy_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> !done_q && !err_q);

  p_fin_ok_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && fin_i && !fin_err_i |=> done_q && !err_q && !busy_q);

  p_fin_err_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && fin_i && fin_err_i |=> err_q && !done_q && $stable(op_q) && $stable(cnt_q));

  p_busy_frozen_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && (ctl_we_i || adr_we_i) |=> $stable(op_q) && $stable(cnt_q) && $stable(faddr_q));
endmodule

// File: rtl/fseq_buffer.sv
module fseq_buffer #(
  parameter int BUF_BYTES = 64,
  localparam int IDX_W    = $clog2(BUF_BYTES),
  localparam int WIDX_W   = IDX_W - 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sw_we_i,
  input  logic [WIDX_W-1:0] sw_widx_i,
  input  logic [3:0]        sw_be_i,
  input  logic [31:0]       sw_wdata_i,
  output logic [31:0]       sw_rdata_o,
  input  logic              eng_we_i,
  input  logic [IDX_W-1:0]  eng_idx_i,
  input  logic [7:0]        eng_wdata_i,
  output logic [7:0]        eng_rdata_o
);
  logic [7:0] mem_q [BUF_BYTES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < BUF_BYTES; b++) mem_q[b] <= '0;
    end else if (eng_we_i) begin
      mem_q[eng_idx_i] <= eng_wdata_i;
    end else if (sw_we_i) begin
      for (int l = 0; l < 4; l++)
        if (sw_be_i[l]) mem_q[{sw_widx_i, 2'(l)}] <= sw_wdata_i[8*l +: 8];
    end
  end

  always_comb begin
    for (int l = 0; l < 4; l++) sw_rdata_o[8*l +: 8] = mem_q[{sw_widx_i, 2'(l)}];
  end

  assign eng_rdata_o = mem_q[eng_idx_i];

  p_one_writer_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sw_we_i && eng_we_i));
endmodule

// File: rtl/fseq_engine.sv
module fseq_engine
  import fseq_pkg::*;
#(
  parameter int BUF_BYTES = 64,
  parameter int ADDR_W    = 32,
  localparam int IDX_W    = $clog2(BUF_BYTES),
  localparam int LEN_W    = IDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        start_op_i,
  input  logic [LEN_W-1:0]  start_len_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [2:0]        cmd_op_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [LEN_W-1:0]  cmd_len_o,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic [7:0]        wr_data_o,
  input  logic              rd_valid_i,
  input  logic [7:0]        rd_data_i,
  input  logic              rsp_valid_i,
  input  logic              rsp_err_i,
  output logic              buf_we_o,
  output logic [IDX_W-1:0]  buf_idx_o,
  output logic [7:0]        buf_wdata_o,
  input  logic [7:0]        buf_rdata_i,
  output logic              fin_o,
  output logic              fin_err_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_CMD, ST_XFER, ST_RSP} st_e;

  st_e               st_q;
  logic [2:0]        op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q, cnt_q;
  logic              is_wr, beat, last;

  assign is_wr = (op_q == OP_WRITE);
  assign beat  = (st_q == ST_XFER) && (is_wr ? wr_ready_i : rd_valid_i);
  assign last  = (cnt_q == len_q - LEN_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      op_q   <= '0;
      addr_q <= '0;
      len_q  <= '0;
      cnt_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q   <= ST_CMD;
          op_q   <= start_op_i;
          addr_q <= start_addr_i;
          len_q  <= start_len_i;
          cnt_q  <= '0;
        end
        ST_CMD:  if (cmd_ready_i) st_q <= (len_q == '0) ? ST_RSP : ST_XFER;
        ST_XFER: if (beat) begin
          cnt_q <= cnt_q + LEN_W'(1);
          if (last) st_q <= ST_RSP;
        end
        ST_RSP:  if (rsp_valid_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_valid_o = (st_q == ST_CMD);
  assign cmd_op_o    = op_q;
  assign cmd_addr_o  = addr_q;
  assign cmd_len_o   = len_q;

  assign wr_valid_o  = (st_q == ST_XFER) && is_wr;
  assign wr_data_o   = buf_rdata_i;

  assign buf_idx_o   = cnt_q[IDX_W-1:0];
  assign buf_we_o    = (st_q == ST_XFER) && !is_wr && rd_valid_i;
  assign buf_wdata_o = rd_data_i;

  assign fin_o       = (st_q == ST_RSP) && rsp_valid_i;
  assign fin_err_o   = rsp_err_i;

  p_cmd_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_op_o) &&
                                    $stable(cmd_addr_o) && $stable(cmd_len_o));

  p_erase_nolen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && op_is_erase(cmd_op_o) |-> cmd_len_o == '0);

  p_wr_stream_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> cmd_op_o == OP_WRITE);

  p_cnt_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_XFER |-> cnt_q < len_q);
endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import fseq_pkg::*;
#(
  parameter int BUF_BYTES = 64,
  parameter int ADDR_W    = 32,
  localparam int IDX_W    = $clog2(BUF_BYTES),
  localparam int LEN_W    = IDX_W + 1,
  localparam int REG_AW   = IDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [3:0]        reg_be_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [2:0]        cmd_op_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [LEN_W-1:0]  cmd_len_o,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic [7:0]        wr_data_o,
  input  logic              rd_valid_i,
  input  logic [7:0]        rd_data_i,
  input  logic              rsp_valid_i,
  input  logic              rsp_err_i
);
  logic sel_buf, sel_ctl, sel_adr;
  assign sel_buf = reg_addr_i[REG_AW-1];
  assign sel_ctl = !sel_buf && (reg_addr_i[REG_AW-2:2] == '0);
  assign sel_adr = !sel_buf && (reg_addr_i[REG_AW-2:2] == (REG_AW-3)'(1));

  logic              start, busy, fin, fin_err;
  logic [2:0]        start_op;
  logic [LEN_W-1:0]  start_len;
  logic [ADDR_W-1:0] faddr;
  logic [31:0]       ctl_word, buf_word;
  logic              eng_we;
  logic [IDX_W-1:0]  eng_idx;
  logic [7:0]        eng_wdata, eng_rdata;

  fseq_regs #(.BUF_BYTES(BUF_BYTES), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni,
    .ctl_we_i    (reg_we_i && sel_ctl),
    .adr_we_i    (reg_we_i && sel_adr),
    .wdata_i     (reg_wdata_i),
    .fin_i       (fin),
    .fin_err_i   (fin_err),
    .start_o     (start),
    .start_op_o  (start_op),
    .start_len_o (start_len),
    .faddr_o     (faddr),
    .busy_o      (busy),
    .ctl_word_o  (ctl_word)
  );

  fseq_buffer #(.BUF_BYTES(BUF_BYTES)) u_buf (
    .clk_i, .rst_ni,
    .sw_we_i     (reg_we_i && sel_buf && !busy),
    .sw_widx_i   (reg_addr_i[REG_AW-2:2]),
    .sw_be_i     (reg_be_i),
    .sw_wdata_i  (reg_wdata_i),
    .sw_rdata_o  (buf_word),
    .eng_we_i    (eng_we),
    .eng_idx_i   (eng_idx),
    .eng_wdata_i (eng_wdata),
    .eng_rdata_o (eng_rdata)
  );

  fseq_engine #(.BUF_BYTES(BUF_BYTES), .ADDR_W(ADDR_W)) u_eng (
    .clk_i, .rst_ni,
    .start_i      (start),
    .start_op_i   (start_op),
    .start_len_i  (start_len),
    .start_addr_i (faddr),
    .cmd_valid_o, .cmd_ready_i, .cmd_op_o, .cmd_addr_o, .cmd_len_o,
    .wr_valid_o, .wr_ready_i, .wr_data_o,
    .rd_valid_i, .rd_data_i,
    .rsp_valid_i, .rsp_err_i,
    .buf_we_o     (eng_we),
    .buf_idx_o    (eng_idx),
    .buf_wdata_o  (eng_wdata),
    .buf_rdata_i  (eng_rdata),
    .fin_o        (fin),
    .fin_err_o    (fin_err)
  );

  always_comb begin
    if (sel_buf)      reg_rdata_o = buf_word;
    else if (sel_ctl) reg_rdata_o = ctl_word;
    else if (sel_adr) reg_rdata_o = 32'(faddr);
    else              reg_rdata_o = '0;
  end

  p_cmd_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> ctl_word[CTL_BUSY]);
endmodule

// File: tb/flash_seq_ctrl_tb.sv
module flash_seq_ctrl_tb;
  localparam logic [6:0] A_CTL = 7'h00, A_ADR = 7'h04, A_BUF = 7'h40;

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic        reg_we = 0;
  logic [6:0]  reg_addr = 0;
  logic [3:0]  reg_be = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        cmd_valid, cmd_ready = 0;
  logic [2:0]  cmd_op;
  logic [31:0] cmd_addr;
  logic [6:0]  cmd_len;
  logic        wr_valid, wr_ready = 0;
  logic [7:0]  wr_data;
  logic        rd_valid = 0;
  logic [7:0]  rd_data = 0;
  logic        rsp_valid = 0, rsp_err = 0;

  flash_seq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_be_i(reg_be),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready), .cmd_op_o(cmd_op),
    .cmd_addr_o(cmd_addr), .cmd_len_o(cmd_len),
    .wr_valid_o(wr_valid), .wr_ready_i(wr_ready), .wr_data_o(wr_data),
    .rd_valid_i(rd_valid), .rd_data_i(rd_data),
    .rsp_valid_i(rsp_valid), .rsp_err_i(rsp_err)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // flash-side model
  logic [7:0] fmem [256];
  logic [7:0] cap [64];
  bit         hold_cmd = 0;
  int         n_cmd = 0, n_wr = 0;
  logic [2:0] m_op;
  logic [31:0] m_addr;
  logic [6:0] m_len;

  always @(posedge clk) if (wr_valid && wr_ready) n_wr++;

  initial begin
    for (int i = 0; i < 256; i++) fmem[i] = 8'(i * 7 + 3);
    forever begin
      @(negedge clk);
      if (cmd_valid && !hold_cmd) begin
        cmd_ready = 1; m_op = cmd_op; m_addr = cmd_addr; m_len = cmd_len; n_cmd++;
        @(negedge clk);
        cmd_ready = 0;
        if (m_op == 3'd2) begin
          for (int k = 0; k < int'(m_len); ) begin
            wr_ready = 1'($urandom % 2);
            if (wr_ready && wr_valid) begin
              cap[k] = wr_data; fmem[8'(m_addr + 32'(k))] = wr_data; k++;
            end
            @(negedge clk);
          end
          wr_ready = 0;
        end else if (m_op == 3'd1 || m_op == 3'd3) begin
          for (int k = 0; k < int'(m_len); ) begin
            rd_valid = 1'($urandom % 2);
            rd_data  = (m_op == 3'd3) ? 8'h5A : fmem[8'(m_addr + 32'(k))];
            if (rd_valid) k++;
            @(negedge clk);
          end
          rd_valid = 0;
        end
        repeat ($urandom % 3) @(negedge clk);
        rsp_valid = 1; rsp_err = (m_addr[31:28] == 4'hF);
        @(negedge clk);
        rsp_valid = 0; rsp_err = 0;
      end
    end
  end

  task automatic wr_reg(input logic [6:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d; reg_be = be;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd_reg(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  function automatic logic [31:0] ctl(input bit go, input bit done, input bit err,
                                      input logic [2:0] op, input logic [7:0] cnt);
    return {15'd0, go, cnt, 1'b0, op, 1'b0, 1'b0, err, done};
  endfunction

  task automatic wait_idle();
    logic [31:0] d;
    for (int t = 0; t < 3000; t++) begin
      rd_reg(A_CTL, d);
      if (!d[2]) return;
    end
  endtask

  task automatic run_op(input logic [2:0] op, input logic [7:0] cnt, input logic [31:0] a);
    wr_reg(A_ADR, a, 4'hF);
    wr_reg(A_CTL, ctl(1, 1, 1, op, cnt), 4'hF);
    wait_idle();
  endtask

  task automatic clear_buf();
    for (int w = 0; w < 16; w++) wr_reg(A_BUF + 7'(4 * w), 32'h0, 4'hF);
  endtask

  logic [7:0]  exp_b [64];
  logic [31:0] d;
  int c0, w0;

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd_reg(A_CTL, d); chk("R1 ctl", d, 32'h0);
    rd_reg(A_ADR, d); chk("R1 addr", d, 32'h0);
    for (int w = 0; w < 16; w++) begin rd_reg(A_BUF + 7'(4 * w), d); chk("R1 buf", d, 32'h0); end
    chk("R1 idle ports", {30'd0, cmd_valid, wr_valid}, 32'h0);

    // R11 byte lanes
    wr_reg(A_BUF + 7'h0C, 32'h11223344, 4'hF);
    wr_reg(A_BUF + 7'h0C, 32'hAABBCCDD, 4'b0100);
    rd_reg(A_BUF + 7'h0C, d); chk("R11 lane2", d, 32'h11BB3344);
    wr_reg(A_BUF + 7'h0C, 32'h55667788, 4'b1001);
    rd_reg(A_BUF + 7'h0C, d); chk("R11 lanes3_0", d, 32'h55BB3388);

    // R2 start: busy on next cycle, go reads 0
    wr_reg(A_ADR, 32'h0000_0120, 4'hF);
    @(negedge clk); reg_we = 1; reg_addr = A_CTL; reg_wdata = ctl(1, 1, 1, 3'd1, 8'd7); reg_be = 4'hF;
    @(negedge clk); reg_we = 0; #1;
    chk("R2 busy after go", reg_rdata, ctl(0, 0, 0, 3'd1, 8'd7) | 32'h4);
    wait_idle();
    chk("R2 cmd fields", {m_op, m_addr[27:0], 1'b0}, {3'd1, 28'h0000120, 1'b0});
    chk("R2 cmd len", 32'(m_len), 32'd8);
    rd_reg(A_CTL, d); chk("R3 done ok", d, ctl(0, 1, 0, 3'd1, 8'd7));

    // R9 write 0 leaves done, write 1 clears
    wr_reg(A_CTL, ctl(0, 0, 0, 3'd1, 8'd7), 4'hF);
    rd_reg(A_CTL, d); chk("R9 zero keeps", d, ctl(0, 1, 0, 3'd1, 8'd7));
    wr_reg(A_CTL, ctl(0, 1, 0, 3'd1, 8'd7), 4'hF);
    rd_reg(A_CTL, d); chk("R9 one clears", d, ctl(0, 0, 0, 3'd1, 8'd7));

    // R4 / R5 random write then read back
    for (int it = 0; it < 16; it++) begin
      int len;
      logic [31:0] a;
      len = (it == 0) ? 64 : (it == 1) ? 1 : 1 + int'($urandom % 64);
      a   = $urandom & 32'h0FFF_FFFF;
      for (int w = 0; w < 16; w++) begin
        logic [31:0] r;
        r = $urandom;
        for (int l = 0; l < 4; l++) exp_b[4*w+l] = r[8*l +: 8];
        wr_reg(A_BUF + 7'(4 * w), r, 4'hF);
      end
      run_op(3'd2, 8'(len - 1), a);
      rd_reg(A_CTL, d); chk("R3 write done", d, ctl(0, 1, 0, 3'd2, 8'(len - 1)));
      chk("R4 write cmd", {m_op, 22'd0, m_len}, {3'd2, 22'd0, 7'(len)});
      begin
        int bad;
        bad = 0;
        for (int k = 0; k < len; k++) if (cap[k] !== exp_b[k]) bad++;
        chk("R4 write bytes order", 32'(bad), 32'd0);
      end
      clear_buf();
      run_op(3'd1, 8'(len - 1), a);
      chk("R5 read cmd addr", m_addr, a);
      begin
        int bad;
        bad = 0;
        for (int w = 0; w < 16; w++) begin
          rd_reg(A_BUF + 7'(4 * w), d);
          for (int l = 0; l < 4; l++)
            if (d[8*l +: 8] !== ((4*w+l < len) ? exp_b[4*w+l] : 8'h00)) bad++;
        end
        chk("R5 read fill", 32'(bad), 32'd0);
      end
    end

    // R5 read-status one byte, upper bytes kept
    wr_reg(A_BUF, 32'hCAFEF00D, 4'hF);
    run_op(3'd3, 8'd0, 32'h0);
    rd_reg(A_BUF, d); chk("R5 read-status", d, 32'hCAFEF05A);

    // R6 erase: len 0, no data beats
    w0 = n_wr; c0 = n_cmd;
    run_op(3'd4, 8'd9, 32'h0000_1000);
    chk("R6 erase4k cmd", {m_op, 22'd0, m_len}, {3'd4, 29'd0});
    run_op(3'd5, 8'd0, 32'h0001_0000);
    chk("R6 erase64k cmd", {m_op, 22'd0, m_len}, {3'd5, 29'd0});
    chk("R6 no data beats", 32'(n_wr - w0), 32'd0);
    chk("R6 two commands", 32'(n_cmd - c0), 32'd2);
    rd_reg(A_CTL, d); chk("R6 done", d, ctl(0, 1, 0, 3'd5, 8'd0));

    // R7 error completion
    run_op(3'd2, 8'd2, 32'hF000_0010);
    rd_reg(A_CTL, d); chk("R7 error status", d, ctl(0, 0, 1, 3'd2, 8'd2));
    wr_reg(A_CTL, 32'h2, 4'hF);
    rd_reg(A_CTL, d); chk("R9 clear error", d, 32'h0);

    // R8 refused requests
    c0 = n_cmd;
    run_op(3'd1, 8'd64, 32'h0);
    rd_reg(A_CTL, d); chk("R8 oversize", d, ctl(0, 0, 1, 3'd1, 8'd64));
    run_op(3'd7, 8'd0, 32'h0);
    rd_reg(A_CTL, d); chk("R8 bad code", d, ctl(0, 0, 1, 3'd7, 8'd0));
    run_op(3'd0, 8'd0, 32'h0);
    rd_reg(A_CTL, d); chk("R8 code zero", d, ctl(0, 0, 1, 3'd0, 8'd0));
    repeat (4) @(negedge clk);
    chk("R8 no command", 32'(n_cmd - c0), 32'd0);

    // R10 writes while busy ignored
    wr_reg(A_BUF + 7'h14, 32'h01020304, 4'hF);
    c0 = n_cmd;
    hold_cmd = 1;
    wr_reg(A_ADR, 32'h0000_0040, 4'hF);
    wr_reg(A_CTL, ctl(1, 1, 1, 3'd1, 8'd3), 4'hF);
    wr_reg(A_CTL, ctl(1, 1, 1, 3'd4, 8'd0), 4'hF);
    wr_reg(A_ADR, 32'h0000_0099, 4'hF);
    wr_reg(A_BUF + 7'h14, 32'hFFFFFFFF, 4'hF);
    rd_reg(A_CTL, d); chk("R10 ctl frozen", d, ctl(0, 0, 0, 3'd1, 8'd3) | 32'h4);
    rd_reg(A_ADR, d); chk("R10 addr frozen", d, 32'h40);
    chk("R12 cmd held", {cmd_valid, cmd_op, cmd_addr[7:0], 1'b0, cmd_len}, {1'b1, 3'd1, 8'h40, 1'b0, 7'd4});
    hold_cmd = 0;
    wait_idle();
    repeat (6) @(negedge clk);
    chk("R10 single command", 32'(n_cmd - c0), 32'd1);
    chk("R10 command kept", {m_op, m_addr[27:0], 1'b0}, {3'd1, 28'h40, 1'b0});
    rd_reg(A_BUF + 7'h14, d); chk("R10 buffer frozen", d, 32'h01020304);

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule